// File: doc/BRIEF.md
# Shared-Pad External Bus Master Port

This block connects an internal AHB master to an off-chip AHB bus that other masters also use. The address, control and data lines leave the chip through bidirectional pads. Ownership of the external bus is decided by an arbiter outside the block, so the block only drives a pad group while this master owns the phase that the group belongs to. At every other time the pads are released so that another master can drive them.

Read and write data never occupy the bus in the same cycle, so one set of data pads carries both. The block drives write data onto the pads only during the data phase of a write that this master issued. It passes whatever is on the pads back to the internal master as read data. The address travels the full width and is never altered.

The bus request and lock outputs to the arbiter are ordinary outputs and are never tristated. They are registered once at the pad. The pad drivers are modelled with conditional high-impedance assignments.

Top module: `xbus_pad_master`

## Requirements
- R1: While reset is high at a clock edge, the block releases the address/control pads and the data pads, and drives `pad_hbusreq` and `pad_hlock` low, from that edge on. Reset is synchronous and active high.
- R2: At an edge where `pad_hready` and `pad_hgrant` are both high, the block takes the address/control pads. From then on `pad_haddr`, `pad_htrans`, `pad_hwrite`, `pad_hsize` and `pad_hburst` carry the internal master's values unchanged.
- R3: At an edge where `pad_hready` is low, ownership of the address/control pads does not change, whatever `pad_hgrant` is.
- R4: At an edge where `pad_hready` is high and `pad_hgrant` is low, the address/control pads are released. Another master's values are then seen on them.
- R5: Transfer codes on `htrans` are IDLE=2'b00, BUSY=2'b01, NONSEQ=2'b10 and SEQ=2'b11. Suppose that at a `pad_hready`-high edge this master owns the address phase and presents NONSEQ or SEQ with `m_hwrite` high. The data pads are then driven with `m_hwdata` for the data phase that follows.
- R6: The data-pad drive holds through every edge with `pad_hready` low. It is released at the `pad_hready`-high edge that ends the phase, unless another owned write starts at that edge.
- R7: An owned read, IDLE or BUSY transfer, or any transfer presented without ownership, leaves the data pads released. The pad value is presented on `m_hrdata`.
- R8: `pad_hbusreq` and `pad_hlock` follow `m_hbusreq` and `m_hlock` one clock later and are always actively driven.
- R9: `m_hready` and `m_hgrant` present `pad_hready` and `pad_hgrant` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| m_haddr | input | AW | Internal master address |
| m_htrans | input | 2 | Internal master transfer type |
| m_hwrite | input | 1 | Internal master write flag |
| m_hsize | input | 3 | Internal master transfer size |
| m_hburst | input | 3 | Internal master burst type |
| m_hwdata | input | DW | Internal master write data |
| m_hbusreq | input | 1 | Internal master bus request |
| m_hlock | input | 1 | Internal master lock request |
| m_hrdata | output | DW | Read data from the pads |
| m_hready | output | 1 | External ready, forwarded |
| m_hgrant | output | 1 | External grant, forwarded |
| pad_haddr | inout | AW | Shared address pads |
| pad_htrans | inout | 2 | Shared transfer type pads |
| pad_hwrite | inout | 1 | Shared write flag pad |
| pad_hsize | inout | 3 | Shared size pads |
| pad_hburst | inout | 3 | Shared burst pads |
| pad_hdata | inout | DW | Shared read/write data pads |
| pad_hready | input | 1 | External transfer-done signal |
| pad_hgrant | input | 1 | Grant from the external arbiter |
| pad_hbusreq | output | 1 | Registered bus request to arbiter |
| pad_hlock | output | 1 | Registered lock to arbiter |

## Verification
The bench drives grant changes during wait states. A design that sampled grant without qualifying it by ready would take or drop the address pads in the middle of another master's transfer. It stretches write data phases with long runs of low ready, which catches a data drive that is released one phase early and collides with the next owner. It interleaves reads, IDLE and BUSY with writes, and ungranted writes, which catches a design that drives the data pads against a returning slave. It also asserts reset while the block owns the bus, to show that every pad drive drops at once.

// File: rtl/xbus_pad_pkg.sv
package xbus_pad_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  function automatic logic trans_moves(input logic [1:0] t);
    return (t == TR_NONSEQ) || (t == TR_SEQ);
  endfunction
endpackage

// File: rtl/xbus_addr_owner.sv
module xbus_addr_owner (
  input  logic clk,
  input  logic rst,
  input  logic bus_ready,
  input  logic bus_grant,
  output logic addr_oe
);
  always_ff @(posedge clk) begin
    if (rst)            addr_oe <= 1'b0;
    else if (bus_ready) addr_oe <= bus_grant;
  end
endmodule

// File: rtl/xbus_wdata_owner.sv
module xbus_wdata_owner
  import xbus_pad_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_ready,
  input  logic       addr_oe,
  input  logic [1:0] trans,
  input  logic       write,
  output logic       data_oe
);
  logic start_wr;
  assign start_wr = addr_oe && trans_moves(trans) && write;

  always_ff @(posedge clk) begin
    if (rst)            data_oe <= 1'b0;
    else if (bus_ready) data_oe <= start_wr;
  end
endmodule

// File: rtl/xbus_arb_regs.sv
module xbus_arb_regs #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= d[i];
    end
  end
endmodule

// File: rtl/xbus_pad_master.sv
module xbus_pad_master #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] m_haddr,
  input  logic [1:0]    m_htrans,
  input  logic          m_hwrite,
  input  logic [2:0]    m_hsize,
  input  logic [2:0]    m_hburst,
  input  logic [DW-1:0] m_hwdata,
  input  logic          m_hbusreq,
  input  logic          m_hlock,
  output logic [DW-1:0] m_hrdata,
  output logic          m_hready,
  output logic          m_hgrant,
  inout  wire  [AW-1:0] pad_haddr,
  inout  wire  [1:0]    pad_htrans,
  inout  wire           pad_hwrite,
  inout  wire  [2:0]    pad_hsize,
  inout  wire  [2:0]    pad_hburst,
  inout  wire  [DW-1:0] pad_hdata,
  input  logic          pad_hready,
  input  logic          pad_hgrant,
  output logic          pad_hbusreq,
  output logic          pad_hlock
);
  localparam int ARB_N = 2;

  logic             addr_oe;
  logic             data_oe;
  logic [ARB_N-1:0] arb_q;

  xbus_addr_owner u_addr (
    .clk(clk), .rst(rst), .bus_ready(pad_hready),
    .bus_grant(pad_hgrant), .addr_oe(addr_oe)
  );

  xbus_wdata_owner u_wdata (
    .clk(clk), .rst(rst), .bus_ready(pad_hready), .addr_oe(addr_oe),
    .trans(m_htrans), .write(m_hwrite), .data_oe(data_oe)
  );

  xbus_arb_regs #(.N(ARB_N)) u_arb (
    .clk(clk), .rst(rst), .d({m_hlock, m_hbusreq}), .q(arb_q)
  );

  assign pad_hbusreq = arb_q[0];
  assign pad_hlock   = arb_q[1];

  assign pad_haddr  = addr_oe ? m_haddr  : {AW{1'bz}};
  assign pad_htrans = addr_oe ? m_htrans : 2'bzz;
  assign pad_hwrite = addr_oe ? m_hwrite : 1'bz;
  assign pad_hsize  = addr_oe ? m_hsize  : 3'bzzz;
  assign pad_hburst = addr_oe ? m_hburst : 3'bzzz;
  assign pad_hdata  = data_oe ? m_hwdata : {DW{1'bz}};

  assign m_hrdata = pad_hdata;
  assign m_hready = pad_hready;
  assign m_hgrant = pad_hgrant;
endmodule

// File: rtl/xbus_pad_master_chk.sv
module xbus_pad_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       pad_hready,
  input logic       pad_hgrant,
  input logic [1:0] m_htrans,
  input logic       m_hwrite,
  input logic       m_hbusreq,
  input logic       pad_hbusreq,
  input logic       addr_oe,
  input logic       data_oe
);
  assert_reset_off_R1: assert property (@(posedge clk)
    rst |=> (!addr_oe && !data_oe && !pad_hbusreq));

  assert_take_bus_R2: assert property (@(posedge clk) disable iff (rst)
    (pad_hready && pad_hgrant) |=> addr_oe);

  assert_wait_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !pad_hready |=> $stable(addr_oe));

  assert_release_R4: assert property (@(posedge clk) disable iff (rst)
    (pad_hready && !pad_hgrant) |=> !addr_oe);

  assert_write_drive_R5: assert property (@(posedge clk) disable iff (rst)
    (pad_hready && addr_oe && m_htrans[1] && m_hwrite) |=> data_oe);

  assert_data_wait_R6: assert property (@(posedge clk) disable iff (rst)
    (data_oe && !pad_hready) |=> data_oe);

  assert_no_read_drive_R7: assert property (@(posedge clk) disable iff (rst)
    (pad_hready && !m_hwrite) |=> !data_oe);

  assert_req_follow_R8: assert property (@(posedge clk) disable iff (rst)
    m_hbusreq |=> pad_hbusreq);
endmodule

bind xbus_pad_master xbus_pad_master_chk chk_i (
  .clk(clk), .rst(rst), .pad_hready(pad_hready), .pad_hgrant(pad_hgrant),
  .m_htrans(m_htrans), .m_hwrite(m_hwrite), .m_hbusreq(m_hbusreq),
  .pad_hbusreq(pad_hbusreq), .addr_oe(addr_oe), .data_oe(data_oe)
);

// File: tb/xbus_pad_master_tb.sv
module xbus_pad_master_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic [AW-1:0] m_haddr = '0;
  logic [1:0]    m_htrans = '0;
  logic          m_hwrite = 1'b0;
  logic [2:0]    m_hsize = '0, m_hburst = '0;
  logic [DW-1:0] m_hwdata = '0;
  logic          m_hbusreq = 1'b0, m_hlock = 1'b0;
  logic [DW-1:0] m_hrdata;
  logic          m_hready, m_hgrant;
  wire  [AW-1:0] pad_haddr;
  wire  [1:0]    pad_htrans;
  wire           pad_hwrite;
  wire  [2:0]    pad_hsize, pad_hburst;
  wire  [DW-1:0] pad_hdata;
  logic          pad_hready = 1'b1, pad_hgrant = 1'b0;
  logic          pad_hbusreq, pad_hlock;

  // other master and slave models on the shared pads
  logic          oth_a_en = 1'b1, oth_d_en = 1'b1;
  logic [AW-1:0] oth_addr = 32'h0BAD_0000;
  logic [1:0]    oth_trans = 2'b00;
  logic          oth_write = 1'b0;
  logic [2:0]    oth_size = 3'd1, oth_burst = 3'd0;
  logic [DW-1:0] slv_rdata = 32'h5A5A_0000;

  assign pad_haddr  = oth_a_en ? oth_addr  : {AW{1'bz}};
  assign pad_htrans = oth_a_en ? oth_trans : 2'bzz;
  assign pad_hwrite = oth_a_en ? oth_write : 1'bz;
  assign pad_hsize  = oth_a_en ? oth_size  : 3'bzzz;
  assign pad_hburst = oth_a_en ? oth_burst : 3'bzzz;
  assign pad_hdata  = oth_d_en ? slv_rdata : {DW{1'bz}};

  xbus_pad_master #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .m_haddr(m_haddr), .m_htrans(m_htrans),
    .m_hwrite(m_hwrite), .m_hsize(m_hsize), .m_hburst(m_hburst),
    .m_hwdata(m_hwdata), .m_hbusreq(m_hbusreq), .m_hlock(m_hlock),
    .m_hrdata(m_hrdata), .m_hready(m_hready), .m_hgrant(m_hgrant),
    .pad_haddr(pad_haddr), .pad_htrans(pad_htrans), .pad_hwrite(pad_hwrite),
    .pad_hsize(pad_hsize), .pad_hburst(pad_hburst), .pad_hdata(pad_hdata),
    .pad_hready(pad_hready), .pad_hgrant(pad_hgrant),
    .pad_hbusreq(pad_hbusreq), .pad_hlock(pad_hlock)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic exp_ao = 1'b0, exp_do = 1'b0, exp_req = 1'b0, exp_lock = 1'b0;

  function automatic logic is_move(input logic [1:0] t);
    return t[1];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model edge, check at next negedge
  task automatic step(input logic r, input logic g, input logic rdy,
                      input logic [1:0] tr, input logic wr);
    rst = r; pad_hgrant = g; pad_hready = rdy;
    m_htrans = tr; m_hwrite = wr;
    m_haddr = $urandom; m_hwdata = $urandom;
    m_hsize = 3'($urandom); m_hburst = 3'($urandom);
    m_hbusreq = 1'($urandom); m_hlock = 1'($urandom);
    oth_addr = $urandom; oth_trans = 2'($urandom); oth_write = 1'($urandom);
    oth_size = 3'($urandom); oth_burst = 3'($urandom);
    slv_rdata = $urandom;
    chk("R9", {m_hready, m_hgrant}, {rdy, g});
    if (r) begin
      exp_ao = 1'b0; exp_do = 1'b0; exp_req = 1'b0; exp_lock = 1'b0;
    end else begin
      exp_req = m_hbusreq; exp_lock = m_hlock;
      if (rdy) begin
        exp_do = exp_ao && is_move(tr) && wr;
        exp_ao = g;
      end
    end
    @(posedge clk); #1;
    oth_a_en = !exp_ao; oth_d_en = !exp_do;
    @(negedge clk);
    chk("R8 R1 busreq", pad_hbusreq, exp_req);
    chk("R8 R1 lock", pad_hlock, exp_lock);
    if (exp_ao) begin
      chk("R2 addr", pad_haddr, m_haddr);
      chk("R2 ctrl", {pad_htrans, pad_hwrite, pad_hsize, pad_hburst},
          {m_htrans, m_hwrite, m_hsize, m_hburst});
    end else begin
      chk("R4 R3 R1 addr released", pad_haddr, oth_addr);
      chk("R4 R3 R1 ctrl released", {pad_htrans, pad_hwrite, pad_hsize, pad_hburst},
          {oth_trans, oth_write, oth_size, oth_burst});
    end
    if (exp_do) begin
      chk("R5 R6 write data", pad_hdata, m_hwdata);
    end else begin
      chk("R7 R1 data released", pad_hdata, slv_rdata);
      chk("R7 read data", m_hrdata, slv_rdata);
    end
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 2'b10, 1'b1);
    // R3: grant during wait is ignored
    step(1'b0, 1'b1, 1'b0, 2'b10, 1'b1);
    step(1'b0, 1'b1, 1'b0, 2'b10, 1'b1);
    // R2: take bus, then R5 write, R6 wait states with grant removed
    step(1'b0, 1'b1, 1'b1, 2'b10, 1'b1);
    step(1'b0, 1'b0, 1'b1, 2'b10, 1'b1);
    step(1'b0, 1'b0, 1'b0, 2'b11, 1'b1);
    step(1'b0, 1'b0, 1'b0, 2'b11, 1'b1);
    // R4, R6: release ends phase
    step(1'b0, 1'b0, 1'b1, 2'b00, 1'b0);
    step(1'b0, 1'b0, 1'b1, 2'b10, 1'b1);
    // R7: owned read, busy, idle
    step(1'b0, 1'b1, 1'b1, 2'b10, 1'b0);
    step(1'b0, 1'b1, 1'b1, 2'b10, 1'b0);
    step(1'b0, 1'b1, 1'b1, 2'b01, 1'b1);
    step(1'b0, 1'b1, 1'b1, 2'b00, 1'b1);
    // R1: reset while owning and writing
    step(1'b0, 1'b1, 1'b1, 2'b10, 1'b1);
    step(1'b1, 1'b1, 1'b0, 2'b10, 1'b1);
    step(1'b0, 1'b0, 1'b0, 2'b10, 1'b1);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 200) == 0, ($urandom % 3) != 0, ($urandom % 4) != 0,
           2'($urandom), 1'($urandom));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule